// File: doc/BRIEF.md
# Preamble-Correlating Frame Aligner with Quadrant Phase Correction

This block takes one frame of recovered QPSK symbols from an external symbol buffer and turns it into message bits. A one-cycle start pulse marks the moment the buffer holds a full frame. The block then slides a 13-symbol Barker reference over every circular offset of the buffer and keeps the offset with the largest correlation. It compares that peak against a programmable threshold. It then takes the quadrant of the peak correlation as the residual carrier rotation (a multiple of 90 degrees). It reads the payload symbols that follow the header, derotates them, demaps them with Gray mapping and removes the additive scrambling. The result is a serial stream of message bits.

The buffer is read through an address output. Symbol data comes back combinationally in the same cycle. If the peak is not above the threshold, the block drops the frame with a one-cycle miss pulse and sends no bits.

A state machine sequences the work. It has five states:
- IDLE waits for a start.
- CORR accumulates one lag per clock.
- CMP compares the finished sum with the best so far.
- DECIDE applies the threshold and picks the quadrant.
- EMIT sends one bit per clock.

It has these transitions:
- IDLE→CORR on a start pulse.
- CORR→CMP after the last lag.
- CMP→CORR while offsets remain.
- CMP→DECIDE after the last offset.
- DECIDE→EMIT when the peak passes the threshold.
- DECIDE→IDLE when it does not.
- EMIT→IDLE after the final message bit.

Top module: `barker_frame_sync`

## Requirements
- R1: While reset is low and in the first cycle after it, busy, sync_found, frame_miss, msg_valid and msg_last are all 0.
- R2: A start pulse is accepted only in IDLE. A start pulse while busy is 1 has no effect, so the frame still yields exactly MSG_BITS bits at the same cycles.
- R3: The Barker signs for header symbol k=0..12 are + + + + + - - + + - + - +. Header symbol k is the sign times (1+j). For offset d, C(d) = sum over k of sign_k*((re+im) + j(im-re)), using the symbol at address (d+k) mod N_SYM. Its magnitude is |Re C|+|Im C|. The reported frame_ofs is the d with the largest magnitude, and ties go to the lowest d.
- R4: sync_found pulses for one cycle only if the peak magnitude is strictly greater than thresh. Otherwise frame_miss pulses for one cycle and no bits are sent.
- R5: frame_rot is taken from the peak C. If |Re|>=|Im|, it is 0 when Re>=0 and 2 when Re<0. If |Im|>|Re|, it is 1 when Im>0 and 3 when Im<0. Codes 0..3 stand for a rotation of 0/90/180/270 degrees.
- R6: Payload symbol j is read at address (frame_ofs+13+j) mod N_SYM. It is multiplied by (-j)^frame_rot. Message bit 2j is 1 when the corrected real part is negative, and bit 2j+1 is 1 when the corrected imaginary part is negative.
- R7: Each demapped bit is XORed with bit 6 of a 7-bit LFSR. The LFSR is loaded with 7'h7F at the start of each payload. After each bit it shifts to {s[5:0], s[6]^s[3]}.
- R8: msg_valid is high for exactly MSG_BITS consecutive cycles, and msg_last is high with the final bit only.
- R9: Count edges from the one that samples a start pulse. The sync_found or frame_miss verdict is visible N_SYM*14+1 edges later. Message bit i follows at N_SYM*14+2+i edges. busy stays high from the start until the last bit is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_go | input | 1 | One-cycle pulse: a full frame is buffered |
| thresh | input | MAG_W | Minimum peak magnitude for acceptance (strictly exceeded) |
| rd_addr | output | IDX_W | Symbol buffer read address |
| sym_re | input | SYM_W | Real part of the addressed symbol, signed |
| sym_im | input | SYM_W | Imaginary part of the addressed symbol, signed |
| busy | output | 1 | High from accepted start until the frame is finished |
| sync_found | output | 1 | One-cycle pulse: frame aligned |
| frame_miss | output | 1 | One-cycle pulse: frame dropped |
| frame_ofs | output | IDX_W | Offset of the peak, valid with sync_found |
| frame_rot | output | 2 | Quadrant code, valid with sync_found |
| msg_valid | output | 1 | Message bit valid |
| msg_bit | output | 1 | Descrambled message bit |
| msg_last | output | 1 | Final message bit of the frame |

## Verification
The assertions assume that frame_go is a single-cycle pulse. They also assume that the buffer returns the symbol for rd_addr in the same cycle and holds its contents still while busy is high. The assertions rely on the block being started only by that pulse. The stimulus keeps to these assumptions by rewriting the buffer only while the block is idle and by raising frame_go for one clock at a time. The one deliberate exception is a pulse placed in the middle of a busy frame. Frames use amplitude-64 symbols with small deterministic noise, so the correlation sums stay well inside the accumulator width.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CORR,
        S_CMP,
        S_DECIDE,
        S_EMIT
    } fsm_t;

    localparam int HDR_LEN = 13;

    // bit k holds the sign of header symbol k (1 = positive)
    localparam logic [HDR_LEN-1:0] HDR_SIGNS = 13'b1010110011111;

endpackage

// File: rtl/bfs_corr_acc.sv
module bfs_corr_acc #(
    parameter int SYM_W = 12,
    parameter int ACC_W = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    pos,
    input  logic signed [SYM_W-1:0] re,
    input  logic signed [SYM_W-1:0] im,
    output logic signed [ACC_W-1:0] acc_re,
    output logic signed [ACC_W-1:0] acc_im
);
    localparam int EXT = ACC_W - SYM_W - 1;

    logic signed [SYM_W:0]   sum_t, dif_t;
    logic signed [ACC_W-1:0] sum_x, dif_x;

    // conj(1+j) * (re + j im) = (re+im) + j(im-re)
    always_comb begin
        sum_t = {re[SYM_W-1], re} + {im[SYM_W-1], im};
        dif_t = {im[SYM_W-1], im} - {re[SYM_W-1], re};
        sum_x = {{EXT{sum_t[SYM_W]}}, sum_t};
        dif_x = {{EXT{dif_t[SYM_W]}}, dif_t};
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_re <= '0;
            acc_im <= '0;
        end else if (en) begin
            if (pos) begin
                acc_re <= acc_re + sum_x;
                acc_im <= acc_im + dif_x;
            end else begin
                acc_re <= acc_re - sum_x;
                acc_im <= acc_im - dif_x;
            end
        end
    end
endmodule

// File: rtl/bfs_peak_track.sv
module bfs_peak_track #(
    parameter int ACC_W = 18,
    parameter int IDX_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    init,
    input  logic                    en,
    input  logic [IDX_W-1:0]        idx,
    input  logic signed [ACC_W-1:0] acc_re,
    input  logic signed [ACC_W-1:0] acc_im,
    output logic [ACC_W:0]          best_mag,
    output logic [IDX_W-1:0]        best_idx,
    output logic signed [ACC_W-1:0] best_re,
    output logic signed [ACC_W-1:0] best_im
);
    logic [ACC_W-1:0] abs_re, abs_im;
    logic [ACC_W:0]   mag;

    always_comb begin
        abs_re = acc_re[ACC_W-1] ? ACC_W'(-acc_re) : ACC_W'(acc_re);
        abs_im = acc_im[ACC_W-1] ? ACC_W'(-acc_im) : ACC_W'(acc_im);
        mag    = {1'b0, abs_re} + {1'b0, abs_im};
    end

    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            best_mag <= '0;
            best_idx <= '0;
            best_re  <= '0;
            best_im  <= '0;
        end else if (en && (mag > best_mag)) begin
            best_mag <= mag;
            best_idx <= idx;
            best_re  <= acc_re;
            best_im  <= acc_im;
        end
    end
endmodule

// File: rtl/bfs_demap.sv
module bfs_demap #(
    parameter int SYM_W = 12
) (
    input  logic signed [SYM_W-1:0] re,
    input  logic signed [SYM_W-1:0] im,
    input  logic [1:0]              rot,
    input  logic                    odd,
    output logic                    bit_o
);
    logic re_neg, im_neg, re_pos, im_pos;
    logic cr_neg, ci_neg;

    always_comb begin
        re_neg = re[SYM_W-1];
        im_neg = im[SYM_W-1];
        re_pos = !re_neg && (re != '0);
        im_pos = !im_neg && (im != '0);
        // sign of the derotated components, no negation needed
        unique case (rot)
            2'd0:    begin cr_neg = re_neg; ci_neg = im_neg; end
            2'd1:    begin cr_neg = im_neg; ci_neg = re_pos; end
            2'd2:    begin cr_neg = re_pos; ci_neg = im_pos; end
            default: begin cr_neg = im_pos; ci_neg = re_neg; end
        endcase
        bit_o = odd ? ci_neg : cr_neg;
    end
endmodule

// File: rtl/bfs_descr.sv
module bfs_descr #(
    parameter int             W    = 7,
    parameter logic [W-1:0]   TAPS = 7'h48,
    parameter logic [W-1:0]   SEED = 7'h7F
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    input  logic din,
    output logic dout
);
    logic [W-1:0] s_q;

    assign dout = din ^ s_q[W-1];

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            s_q <= SEED;
        end else if (step) begin
            s_q <= {s_q[W-2:0], ^(s_q & TAPS)};
        end
    end
endmodule

// File: rtl/barker_frame_sync.sv
module barker_frame_sync
    import bfs_pkg::*;
#(
    parameter int             N_SYM     = 100,
    parameter int             SYM_W     = 12,
    parameter int             MSG_BITS  = 105,
    parameter int             LFSR_W    = 7,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 7'h48,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 7'h7F,
    localparam int IDX_W = $clog2(N_SYM),
    localparam int ACC_W = SYM_W + 2 + $clog2(HDR_LEN),
    localparam int MAG_W = ACC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_go,
    input  logic [MAG_W-1:0]        thresh,
    output logic [IDX_W-1:0]        rd_addr,
    input  logic signed [SYM_W-1:0] sym_re,
    input  logic signed [SYM_W-1:0] sym_im,
    output logic                    busy,
    output logic                    sync_found,
    output logic                    frame_miss,
    output logic [IDX_W-1:0]        frame_ofs,
    output logic [1:0]              frame_rot,
    output logic                    msg_valid,
    output logic                    msg_bit,
    output logic                    msg_last
);
    localparam int KW    = $clog2(HDR_LEN);
    localparam int BC_W  = $clog2(MSG_BITS);
    localparam int SUM_W = IDX_W + 1;
    localparam logic [KW-1:0]    K_LAST   = KW'(HDR_LEN - 1);
    localparam logic [IDX_W-1:0] D_LAST   = IDX_W'(N_SYM - 1);
    localparam logic [BC_W-1:0]  B_LAST   = BC_W'(MSG_BITS - 1);
    localparam logic [SUM_W-1:0] N_WIDE   = SUM_W'(N_SYM);
    localparam logic [SUM_W-1:0] HDR_WIDE = SUM_W'(HDR_LEN);

    fsm_t state_q, state_d;

    logic [IDX_W-1:0] d_q, ofs_q;
    logic [KW-1:0]    k_q;
    logic [BC_W-1:0]  bcnt_q;
    logic [1:0]       rot_q, rot_d;
    logic             accept;

    logic signed [ACC_W-1:0] acc_re, acc_im, best_re, best_im;
    logic [ACC_W:0]          best_mag;
    logic [IDX_W-1:0]        best_idx;
    logic [ACC_W-1:0]        babs_re, babs_im;
    logic                    raw_bit, clean_bit;
    logic [SUM_W-1:0]        addr_sum;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (frame_go) state_d = S_CORR;
            S_CORR:   if (k_q == K_LAST) state_d = S_CMP;
            S_CMP:    state_d = (d_q == D_LAST) ? S_DECIDE : S_CORR;
            S_DECIDE: state_d = accept ? S_EMIT : S_IDLE;
            S_EMIT:   if (bcnt_q == B_LAST) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- counters and captured decision ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q    <= '0;
            k_q    <= '0;
            bcnt_q <= '0;
            ofs_q  <= '0;
            rot_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    d_q <= '0;
                    k_q <= '0;
                end
                S_CORR:   k_q <= (k_q == K_LAST) ? '0 : k_q + 1'b1;
                S_CMP:    d_q <= (d_q == D_LAST) ? '0 : d_q + 1'b1;
                S_DECIDE: begin
                    ofs_q  <= best_idx;
                    rot_q  <= rot_d;
                    bcnt_q <= '0;
                end
                S_EMIT:   bcnt_q <= bcnt_q + 1'b1;
                default: ;
            endcase
        end
    end

    // ---------------- buffer address ----------------
    always_comb begin
        if (state_q == S_EMIT)
            addr_sum = {1'b0, ofs_q} + HDR_WIDE + SUM_W'(bcnt_q >> 1);
        else
            addr_sum = {1'b0, d_q} + SUM_W'(k_q);
        if (addr_sum >= N_WIDE) addr_sum = addr_sum - N_WIDE;
        rd_addr = addr_sum[IDX_W-1:0];
    end

    // ---------------- quadrant and threshold decision ----------------
    always_comb begin
        babs_re = best_re[ACC_W-1] ? ACC_W'(-best_re) : ACC_W'(best_re);
        babs_im = best_im[ACC_W-1] ? ACC_W'(-best_im) : ACC_W'(best_im);
        if (babs_re >= babs_im) rot_d = best_re[ACC_W-1] ? 2'd2 : 2'd0;
        else                    rot_d = best_im[ACC_W-1] ? 2'd3 : 2'd1;
        accept = best_mag > thresh;
    end

    // ---------------- datapath units ----------------
    bfs_corr_acc #(.SYM_W(SYM_W), .ACC_W(ACC_W)) u_corr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state_q != S_CORR),
        .en     (state_q == S_CORR),
        .pos    (HDR_SIGNS[k_q]),
        .re     (sym_re),
        .im     (sym_im),
        .acc_re (acc_re),
        .acc_im (acc_im)
    );

    bfs_peak_track #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_peak (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (state_q == S_IDLE),
        .en       (state_q == S_CMP),
        .idx      (d_q),
        .acc_re   (acc_re),
        .acc_im   (acc_im),
        .best_mag (best_mag),
        .best_idx (best_idx),
        .best_re  (best_re),
        .best_im  (best_im)
    );

    bfs_demap #(.SYM_W(SYM_W)) u_demap (
        .re    (sym_re),
        .im    (sym_im),
        .rot   (rot_q),
        .odd   (bcnt_q[0]),
        .bit_o (raw_bit)
    );

    bfs_descr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_descr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state_q == S_DECIDE),
        .step  (state_q == S_EMIT),
        .din   (raw_bit),
        .dout  (clean_bit)
    );

    assign busy = (state_q != S_IDLE);

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_found <= 1'b0;
            frame_miss <= 1'b0;
            frame_ofs  <= '0;
            frame_rot  <= '0;
            msg_valid  <= 1'b0;
            msg_bit    <= 1'b0;
            msg_last   <= 1'b0;
        end else begin
            sync_found <= (state_q == S_DECIDE) && accept;
            frame_miss <= (state_q == S_DECIDE) && !accept;
            if (state_q == S_DECIDE && accept) begin
                frame_ofs <= best_idx;
                frame_rot <= rot_d;
            end
            msg_valid <= (state_q == S_EMIT);
            msg_bit   <= (state_q == S_EMIT) && clean_bit;
            msg_last  <= (state_q == S_EMIT) && (bcnt_q == B_LAST);
        end
    end
endmodule

// File: rtl/barker_frame_sync_chk.sv
module barker_frame_sync_chk #(
    parameter int N_SYM    = 100,
    parameter int MSG_BITS = 105,
    parameter int IDX_W    = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_go,
    input logic             busy,
    input logic             sync_found,
    input logic             frame_miss,
    input logic [IDX_W-1:0] frame_ofs,
    input logic             msg_valid,
    input logic             msg_last
);
    logic [15:0] bits_seen;

    always_ff @(posedge clk) begin
        if (!rst_n)          bits_seen <= '0;
        else if (sync_found) bits_seen <= '0;
        else if (msg_valid)  bits_seen <= bits_seen + 1'b1;
    end

    p_start_needs_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(frame_go));

    p_ofs_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_found |-> (frame_ofs < IDX_W'(N_SYM)));

    p_one_verdict_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_found && frame_miss));

    p_bits_after_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(sync_found));

    p_last_is_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_last |-> msg_valid);

    p_last_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_last |=> !msg_valid);

    p_bit_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_last |-> (bits_seen == 16'(MSG_BITS - 1)));

    p_verdict_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_found || frame_miss) |-> $past(busy));
endmodule

bind barker_frame_sync barker_frame_sync_chk #(
    .N_SYM(N_SYM), .MSG_BITS(MSG_BITS), .IDX_W(IDX_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_go   (frame_go),
    .busy       (busy),
    .sync_found (sync_found),
    .frame_miss (frame_miss),
    .frame_ofs  (frame_ofs),
    .msg_valid  (msg_valid),
    .msg_last   (msg_last)
);

// File: tb/test_barker_frame_sync.sv
`timescale 1ns/1ps
module test_barker_frame_sync;
    localparam int N    = 100;
    localparam int HDR  = 13;
    localparam int MSGB = 105;
    localparam int T_V  = N * (HDR + 1) + 1;
    localparam int AMP  = 64;

    logic clk = 1'b0, rst_n = 1'b0, frame_go = 1'b0;
    logic [18:0] thresh = '0;
    logic [6:0]  rd_addr;
    logic signed [11:0] sym_re, sym_im;
    logic busy, sync_found, frame_miss, msg_valid, msg_bit, msg_last;
    logic [6:0] frame_ofs;
    logic [1:0] frame_rot;

    logic signed [11:0] mem_re [N];
    logic signed [11:0] mem_im [N];

    int vectors = 0, fails = 0;
    int unsigned lcg = 32'h1234_5678;
    bit exp_bits [MSGB];
    bit msg_ref  [MSGB];
    int m_ok, m_ofs, m_rot, m_peak;
    int hdr_sign [HDR] = '{1,1,1,1,1,-1,-1,1,1,-1,1,-1,1};
    string text = "Hello world 042";

    always #5 clk = ~clk;

    assign sym_re = (rd_addr < 7'(N)) ? mem_re[rd_addr] : '0;
    assign sym_im = (rd_addr < 7'(N)) ? mem_im[rd_addr] : '0;

    barker_frame_sync i_barker_frame_sync (
        .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .thresh(thresh),
        .rd_addr(rd_addr), .sym_re(sym_re), .sym_im(sym_im), .busy(busy),
        .sync_found(sync_found), .frame_miss(frame_miss), .frame_ofs(frame_ofs),
        .frame_rot(frame_rot), .msg_valid(msg_valid), .msg_bit(msg_bit),
        .msg_last(msg_last)
    );

    function automatic int rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return int'(lcg >> 16);
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic chk(input bit good, input string tag, input int act, input int exp);
        vectors++;
        if (!good) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // transmit side: header, scrambled message + filler, rotation, noise
    task automatic build(input int d, input int q, input bit blank);
        bit pay [2*(N-HDR)];
        bit [6:0] s = 7'h7F;
        for (int i = 0; i < MSGB; i++) msg_ref[i] = text[i/7][6 - (i%7)];
        for (int i = 0; i < 2*(N-HDR); i++) begin
            bit b = (i < MSGB) ? msg_ref[i] : bit'(rnd() & 1);
            pay[i] = b ^ s[6];
            s = {s[5:0], s[6] ^ s[3]};
        end
        for (int p = 0; p < N; p++) begin
            int re, im, t;
            if (p < HDR) begin
                re = hdr_sign[p] * AMP; im = re;
            end else begin
                re = pay[2*(p-HDR)]   ? -AMP : AMP;
                im = pay[2*(p-HDR)+1] ? -AMP : AMP;
            end
            for (int r = 0; r < q; r++) begin t = re; re = -im; im = t; end
            re += (rnd() % 7) - 3;
            im += (rnd() % 7) - 3;
            if (blank) begin re = 0; im = 0; end
            mem_re[(d+p)%N] = 12'(re);
            mem_im[(d+p)%N] = 12'(im);
        end
    endtask

    // reference model of the requirements
    task automatic model(input int thr);
        int bm = 0, bd = 0, br = 0, bi = 0;
        bit [6:0] s = 7'h7F;
        for (int d = 0; d < N; d++) begin
            int cr = 0, ci = 0, m;
            for (int k = 0; k < HDR; k++) begin
                int re = mem_re[(d+k)%N], im = mem_im[(d+k)%N];
                cr += hdr_sign[k] * (re + im);
                ci += hdr_sign[k] * (im - re);
            end
            m = iabs(cr) + iabs(ci);
            if (m > bm) begin bm = m; bd = d; br = cr; bi = ci; end
        end
        if (iabs(br) >= iabs(bi)) m_rot = (br < 0) ? 2 : 0;
        else                      m_rot = (bi < 0) ? 3 : 1;
        m_ofs = bd; m_peak = bm; m_ok = (bm > thr);
        for (int n = 0; n < MSGB; n++) begin
            int re = mem_re[(bd + HDR + n/2) % N], im = mem_im[(bd + HDR + n/2) % N];
            for (int r = 0; r < m_rot; r++) begin int t = re; re = im; im = -t; end
            exp_bits[n] = ((n % 2 == 0) ? (re < 0) : (im < 0)) ^ s[6];
            s = {s[5:0], s[6] ^ s[3]};
        end
    endtask

    task automatic run_frame(input int thr, input bit go_mid);
        int seen = 0;
        thresh = 19'(thr);
        model(thr);
        @(negedge clk) frame_go = 1'b1;
        @(posedge clk);
        for (int n = 0; n <= T_V + MSGB + 2; n++) begin
            bit eb, es, em, ev, el;
            if (n > 0) @(posedge clk);
            @(negedge clk);
            frame_go = (go_mid && n == 700);
            eb = m_ok ? (n <= T_V + MSGB - 1) : (n <= T_V - 1);
            es = m_ok && n == T_V;
            em = !m_ok && n == T_V;
            ev = m_ok && n >= T_V + 1 && n < T_V + 1 + MSGB;
            el = m_ok && n == T_V + MSGB;
            chk(busy == eb, "R9 busy", busy, eb);
            chk(sync_found == es, "R4 sync_found", sync_found, es);
            chk(frame_miss == em, "R4 frame_miss", frame_miss, em);
            chk(msg_valid == ev, "R8 msg_valid", msg_valid, ev);
            chk(msg_last == el, "R8 msg_last", msg_last, el);
            if (msg_valid) seen++;
            if (ev) chk(msg_bit == exp_bits[n-T_V-1], "R6 R7 msg_bit", msg_bit, exp_bits[n-T_V-1]);
            if (es) begin
                chk(frame_ofs == 7'(m_ofs), "R3 frame_ofs", frame_ofs, m_ofs);
                chk(frame_rot == 2'(m_rot), "R5 frame_rot", frame_rot, m_rot);
            end
        end
        if (go_mid) chk(seen == MSGB, "R2 bits with mid-frame start", seen, MSGB);
    endtask

    task automatic planted(input int d, input int q, input int thr, input bit go_mid);
        build(d, q, 1'b0);
        model(thr);
        chk(m_ofs == d, "R3 model offset vs planted", m_ofs, d);
        chk(m_rot == q, "R5 model quadrant vs planted", m_rot, q);
        for (int i = 0; i < MSGB; i++)
            if (exp_bits[i] != msg_ref[i]) chk(0, "R7 recovered message", exp_bits[i], msg_ref[i]);
        run_frame(thr, go_mid);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin mem_re[i] = '0; mem_im[i] = '0; end
        repeat (3) @(negedge clk);
        chk({busy, sync_found, frame_miss, msg_valid, msg_last} == 5'b0, "R1 in reset",
            {busy, sync_found, frame_miss, msg_valid, msg_last}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, sync_found, frame_miss, msg_valid, msg_last} == 5'b0, "R1 after reset",
            {busy, sync_found, frame_miss, msg_valid, msg_last}, 0);
        planted(0, 0, 800, 1'b0);
        planted(37, 1, 800, 1'b0);
        planted(95, 2, 800, 1'b0);     // header wraps the buffer end
        planted(60, 3, 800, 1'b1);     // R2: start pulse while busy
        build(12, 0, 1'b0);
        model(0);
        run_frame(m_peak, 1'b0);       // R4: equal to threshold is dropped
        run_frame(m_peak - 1, 1'b0);   // R4: one above is accepted
        run_frame(5000, 1'b0);         // R4: far below threshold
        build(0, 0, 1'b1);
        run_frame(0, 1'b0);            // all-zero buffer
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule